// File: doc/BRIEF.md
# Two-Port Banked RAM with Collision Serialization

This block is a banked on-chip RAM shared by two access ports. One port carries instruction and coefficient fetches; the other carries data-space loads and stores. Each address splits into a bank index (upper bits) and an offset inside that bank (lower bits). Every bank can take its address, write data and enable from either port. Two accesses to different banks in the same cycle therefore both complete at once.

When both ports reference the same bank in the same cycle, the bank performs the data-port access in that cycle. It raises a stall toward the instruction side for one cycle and performs the held instruction access in the next cycle. The requesting core freezes its instruction request for that single wait-state.

An address whose bank index names a bank that is not fitted raises an out-of-range flag. That access writes nothing and returns no read data. The bank count is a parameter; typical builds fit 16 or 10 banks of 1024 words of 16 bits.

Top module: `bank_ram_arb`

## Requirements
- R1: After reset, with no requests, i_stall_o, i_rvalid_o, d_rvalid_o, i_oor_o and d_oor_o are all low.
- R2: Address bits [ADDR_W-1:OFF_W] select the bank and bits [OFF_W-1:0] select the word. A word written through one port reads back the same value through the other port.
- R3: A granted read returns its data with rvalid high on the cycle after the grant.
- R4: Requests from both ports to different fitted banks in one cycle are both granted in that cycle, with i_stall_o low.
- R5: When both ports request the same fitted bank in a cycle that is not a wait-state, i_stall_o is high in that cycle and low in the next, and the data access is performed in the first cycle.
- R6: The instruction access held by a stall is performed in the following cycle. For a read, i_rvalid_o is high one cycle after that.
- R7: On a same-bank collision where the data port writes the word that the instruction port reads, the instruction read returns the newly written value.
- R8: A request whose bank index is N_BANKS or above raises that port's oor flag in the same cycle. It writes nothing, returns no rvalid and never causes a stall.
- R9: A data-port request presented during the inserted wait-state is not performed. No write occurs and no rvalid follows.
- R10: Writes from the instruction port land in the addressed word and can be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| i_req_i | input | 1 | Instruction-port request |
| i_we_i | input | 1 | Instruction-port write enable |
| i_addr_i | input | ADDR_W | Instruction-port word address |
| i_wdata_i | input | DATA_W | Instruction-port write data |
| i_rdata_o | output | DATA_W | Instruction-port read data |
| i_rvalid_o | output | 1 | Instruction-port read data valid |
| i_stall_o | output | 1 | Instruction-port wait-state request |
| i_oor_o | output | 1 | Instruction-port address out of range |
| d_req_i | input | 1 | Data-port request |
| d_we_i | input | 1 | Data-port write enable |
| d_addr_i | input | ADDR_W | Data-port word address |
| d_wdata_i | input | DATA_W | Data-port write data |
| d_rdata_o | output | DATA_W | Data-port read data |
| d_rvalid_o | output | 1 | Data-port read data valid |
| d_oor_o | output | 1 | Data-port address out of range |

## Verification
The hardest case is the ordering inside a collision. It only shows when both ports touch the very same word, with a write on the data side and a read on the instruction side. If the order were reversed, the read would return the stale value. The stimulus therefore preloads a known word, then issues a colliding store and fetch to it and holds the fetch through the stall. A second collision drives a data-port store into the wait-state cycle itself, and a later read confirms that the store was dropped.

// File: rtl/bank_ram_pkg.sv
package bank_ram_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_D    = 2'd1,
    SRC_I    = 2'd2
  } bank_src_e;
endpackage

// File: rtl/bank_addr_dec.sv
module bank_addr_dec #(
  parameter int N_BANKS = 10,
  parameter int BANK_W  = 4,
  parameter int OFF_W   = 8,
  localparam int ADDR_W = BANK_W + OFF_W
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [OFF_W-1:0]  off_o,
  output logic              oor_o
);
  assign bank_o = addr_i[ADDR_W-1:OFF_W];
  assign off_o  = addr_i[OFF_W-1:0];

  generate
    if (N_BANKS == (1 << BANK_W)) begin : g_full
      assign oor_o = 1'b0;
    end else begin : g_partial
      assign oor_o = req_i && (bank_o > BANK_W'(N_BANKS - 1));
    end
  endgenerate
endmodule

// File: rtl/bank_arbiter.sv
module bank_arbiter #(
  parameter int BANK_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              i_req_i,
  input  logic              i_oor_i,
  input  logic [BANK_W-1:0] i_bank_i,
  input  logic              d_req_i,
  input  logic              d_oor_i,
  input  logic [BANK_W-1:0] d_bank_i,
  output logic              i_gnt_o,
  output logic              d_gnt_o,
  output logic              stall_o
);
  logic wait_q;
  logic coll;

  // collision only outside the wait-state; the held fetch wins that cycle
  assign coll    = i_req_i && d_req_i && !i_oor_i && !d_oor_i &&
                   (i_bank_i == d_bank_i) && !wait_q;
  assign d_gnt_o = d_req_i && !d_oor_i && !wait_q;
  assign i_gnt_o = i_req_i && !i_oor_i && !coll;
  assign stall_o = coll;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wait_q <= 1'b0;
    else         wait_q <= coll;
  end
endmodule

// File: rtl/ram_bank.sv
module ram_bank #(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 8,
  localparam int DEPTH = 1 << OFF_W
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem[off_i] <= wdata_i;
      else      rdata_o    <= mem[off_i];
    end
  end
endmodule

// File: rtl/bank_ram_arb.sv
module bank_ram_arb #(
  parameter int N_BANKS    = 10,
  parameter int BANK_WORDS = 256,
  parameter int DATA_W     = 16,
  localparam int OFF_W     = $clog2(BANK_WORDS),
  localparam int BANK_W    = (N_BANKS > 1) ? $clog2(N_BANKS) : 1,
  localparam int ADDR_W    = BANK_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              i_req_i,
  input  logic              i_we_i,
  input  logic [ADDR_W-1:0] i_addr_i,
  input  logic [DATA_W-1:0] i_wdata_i,
  output logic [DATA_W-1:0] i_rdata_o,
  output logic              i_rvalid_o,
  output logic              i_stall_o,
  output logic              i_oor_o,
  input  logic              d_req_i,
  input  logic              d_we_i,
  input  logic [ADDR_W-1:0] d_addr_i,
  input  logic [DATA_W-1:0] d_wdata_i,
  output logic [DATA_W-1:0] d_rdata_o,
  output logic              d_rvalid_o,
  output logic              d_oor_o
);
  import bank_ram_pkg::*;

  logic [BANK_W-1:0] i_bank, d_bank;
  logic [OFF_W-1:0]  i_off, d_off;
  logic              i_gnt, d_gnt;
  logic [DATA_W-1:0] bank_rdata [N_BANKS];

  bank_addr_dec #(.N_BANKS(N_BANKS), .BANK_W(BANK_W), .OFF_W(OFF_W)) u_i_dec (
    .req_i (i_req_i), .addr_i(i_addr_i),
    .bank_o(i_bank),  .off_o (i_off), .oor_o(i_oor_o)
  );

  bank_addr_dec #(.N_BANKS(N_BANKS), .BANK_W(BANK_W), .OFF_W(OFF_W)) u_d_dec (
    .req_i (d_req_i), .addr_i(d_addr_i),
    .bank_o(d_bank),  .off_o (d_off), .oor_o(d_oor_o)
  );

  bank_arbiter #(.BANK_W(BANK_W)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .i_req_i (i_req_i),
    .i_oor_i (i_oor_o),
    .i_bank_i(i_bank),
    .d_req_i (d_req_i),
    .d_oor_i (d_oor_o),
    .d_bank_i(d_bank),
    .i_gnt_o (i_gnt),
    .d_gnt_o (d_gnt),
    .stall_o (i_stall_o)
  );

  for (genvar k = 0; k < N_BANKS; k++) begin : g_bank
    bank_src_e         src;
    logic              b_we;
    logic [OFF_W-1:0]  b_off;
    logic [DATA_W-1:0] b_wdata;

    always_comb begin
      if (d_gnt && d_bank == BANK_W'(k))      src = SRC_D;
      else if (i_gnt && i_bank == BANK_W'(k)) src = SRC_I;
      else                                    src = SRC_NONE;
    end

    always_comb begin
      unique case (src)
        SRC_D: begin b_we = d_we_i; b_off = d_off; b_wdata = d_wdata_i; end
        SRC_I: begin b_we = i_we_i; b_off = i_off; b_wdata = i_wdata_i; end
        default: begin b_we = 1'b0; b_off = '0; b_wdata = '0; end
      endcase
    end

    ram_bank #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_bank (
      .clk_i  (clk_i),
      .en_i   (src != SRC_NONE),
      .we_i   (b_we),
      .off_i  (b_off),
      .wdata_i(b_wdata),
      .rdata_o(bank_rdata[k])
    );
  end

  logic              i_rd_q, d_rd_q;
  logic [BANK_W-1:0] i_bank_q, d_bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_rd_q   <= 1'b0;
      d_rd_q   <= 1'b0;
      i_bank_q <= '0;
      d_bank_q <= '0;
    end else begin
      i_rd_q <= i_gnt && !i_we_i;
      d_rd_q <= d_gnt && !d_we_i;
      if (i_gnt) i_bank_q <= i_bank;
      if (d_gnt) d_bank_q <= d_bank;
    end
  end

  assign i_rvalid_o = i_rd_q;
  assign d_rvalid_o = d_rd_q;
  assign i_rdata_o  = bank_rdata[i_bank_q];
  assign d_rdata_o  = bank_rdata[d_bank_q];
endmodule

// File: rtl/bank_ram_arb_chk.sv
module bank_ram_arb_chk #(
  parameter int BANK_W = 4,
  parameter int OFF_W  = 8,
  localparam int ADDR_W = BANK_W + OFF_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              i_req_i,
  input logic              i_we_i,
  input logic [ADDR_W-1:0] i_addr_i,
  input logic              i_rvalid_o,
  input logic              i_stall_o,
  input logic              i_oor_o,
  input logic              d_req_i,
  input logic              d_we_i,
  input logic [ADDR_W-1:0] d_addr_i,
  input logic              d_rvalid_o,
  input logic              d_oor_o
);
  logic stall_q;
  logic same_bank;

  assign same_bank = i_addr_i[ADDR_W-1:OFF_W] == d_addr_i[ADDR_W-1:OFF_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stall_q <= 1'b0;
    else         stall_q <= i_stall_o;
  end

  p_stall_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    i_stall_o |-> (i_req_i && d_req_i && !i_oor_o && !d_oor_o && same_bank));

  p_stall_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    i_stall_o |=> !i_stall_o);

  p_held_fetch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    i_stall_o |=> (i_req_i && $stable(i_addr_i) && $stable(i_we_i)));

  p_late_fetch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i_stall_o && !i_we_i) |=> ##1 i_rvalid_o);

  p_d_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_req_i && !d_we_i && !d_oor_o && !stall_q) |=> d_rvalid_o);

  p_wait_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_q |=> !d_rvalid_o);

  p_oor_silent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_oor_o && !(i_req_i && !i_oor_o && !i_we_i && !stall_q)) |=> !d_rvalid_o);

  p_no_stall_split_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i_req_i && d_req_i && !same_bank) |-> !i_stall_o);
endmodule

bind bank_ram_arb bank_ram_arb_chk #(.BANK_W(BANK_W), .OFF_W(OFF_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .i_req_i   (i_req_i),
  .i_we_i    (i_we_i),
  .i_addr_i  (i_addr_i),
  .i_rvalid_o(i_rvalid_o),
  .i_stall_o (i_stall_o),
  .i_oor_o   (i_oor_o),
  .d_req_i   (d_req_i),
  .d_we_i    (d_we_i),
  .d_addr_i  (d_addr_i),
  .d_rvalid_o(d_rvalid_o),
  .d_oor_o   (d_oor_o)
);

// File: tb/bank_ram_arb_test.sv
module bank_ram_arb_test;
  localparam int N_BANKS    = 10;
  localparam int BANK_WORDS = 256;
  localparam int DATA_W     = 16;
  localparam int OFF_W      = $clog2(BANK_WORDS);
  localparam int BANK_W     = $clog2(N_BANKS);
  localparam int ADDR_W     = BANK_W + OFF_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic i_req, i_we, d_req, d_we;
  logic [ADDR_W-1:0] i_addr, d_addr;
  logic [DATA_W-1:0] i_wdata, d_wdata, i_rdata, d_rdata;
  logic i_rvalid, d_rvalid, i_stall, i_oor, d_oor;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  bank_ram_arb #(.N_BANKS(N_BANKS), .BANK_WORDS(BANK_WORDS), .DATA_W(DATA_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .i_req_i(i_req), .i_we_i(i_we), .i_addr_i(i_addr), .i_wdata_i(i_wdata),
    .i_rdata_o(i_rdata), .i_rvalid_o(i_rvalid), .i_stall_o(i_stall), .i_oor_o(i_oor),
    .d_req_i(d_req), .d_we_i(d_we), .d_addr_i(d_addr), .d_wdata_i(d_wdata),
    .d_rdata_o(d_rdata), .d_rvalid_o(d_rvalid), .d_oor_o(d_oor)
  );

  function automatic logic [ADDR_W-1:0] mk(int bank, int off);
    return ADDR_W'((bank << OFF_W) | off);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    i_req = 0; i_we = 0; i_addr = '0; i_wdata = '0;
    d_req = 0; d_we = 0; d_addr = '0; d_wdata = '0;
  endtask

  task automatic d_op(logic we, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] w);
    d_req = 1; d_we = we; d_addr = a; d_wdata = w;
  endtask

  task automatic i_op(logic we, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] w);
    i_req = 1; i_we = we; i_addr = a; i_wdata = w;
  endtask

  task automatic t_reset();
    chk("R1 stall", i_stall, 0);
    chk("R1 i_rvalid", i_rvalid, 0);
    chk("R1 d_rvalid", d_rvalid, 0);
    chk("R1 oor", {i_oor, d_oor}, 0);
  endtask

  task automatic t_cross_port();
    idle(); d_op(1, mk(2, 5), 16'hBEEF); step();
    idle(); i_op(0, mk(2, 5), 0); #1;
    chk("R2 no stall", i_stall, 0);
    step();
    chk("R2 i_rvalid", i_rvalid, 1);
    chk("R2 data", i_rdata, 16'hBEEF);
    idle(); d_op(0, mk(2, 5), 0); step();
    chk("R3 d_rvalid", d_rvalid, 1);
    chk("R3 d_rdata", d_rdata, 16'hBEEF);
    idle(); step();
    chk("R3 idle rvalid", d_rvalid, 0);
  endtask

  task automatic t_split_banks();
    idle(); i_op(1, mk(1, 0), 16'hA1A1); d_op(1, mk(9, 0), 16'hB2B2); #1;
    chk("R10 split write no stall", i_stall, 0);
    step();
    idle(); i_op(0, mk(9, 0), 0); d_op(0, mk(1, 0), 0); #1;
    chk("R4 no stall", i_stall, 0);
    step();
    chk("R4 i_rvalid", i_rvalid, 1);
    chk("R4 d_rvalid", d_rvalid, 1);
    chk("R10 i-written word", d_rdata, 16'hA1A1);
    chk("R4 i data", i_rdata, 16'hB2B2);
  endtask

  task automatic t_collide_order();
    idle(); d_op(1, mk(3, 7), 16'h1111); step();
    idle(); d_op(1, mk(3, 7), 16'h2222); i_op(0, mk(3, 7), 0); #1;
    chk("R5 stall raised", i_stall, 1);
    step();
    d_req = 0; d_we = 0; #1;
    chk("R5 stall dropped", i_stall, 0);
    chk("R6 no early i_rvalid", i_rvalid, 0);
    step();
    chk("R6 i_rvalid", i_rvalid, 1);
    chk("R7 new value", i_rdata, 16'h2222);
    idle(); step();
  endtask

  task automatic t_collide_reads();
    idle(); d_op(1, mk(4, 1), 16'h0A0A); step();
    idle(); d_op(1, mk(4, 2), 16'h0B0B); step();
    idle(); d_op(0, mk(4, 1), 0); i_op(0, mk(4, 2), 0); #1;
    chk("R5 read collision stall", i_stall, 1);
    step();
    d_req = 0; #1;
    chk("R3 d first valid", d_rvalid, 1);
    chk("R5 d first data", d_rdata, 16'h0A0A);
    chk("R6 i waits", i_rvalid, 0);
    step();
    chk("R6 i late valid", i_rvalid, 1);
    chk("R6 i late data", i_rdata, 16'h0B0B);
    idle(); step();
  endtask

  task automatic t_wait_drop();
    idle(); d_op(1, mk(5, 0), 16'h4444); step();
    idle(); d_op(1, mk(6, 3), 16'h6666); step();
    idle(); d_op(0, mk(6, 3), 0); i_op(0, mk(6, 3), 0); step();
    d_op(1, mk(5, 0), 16'h5555); #1;
    chk("R9 stall single", i_stall, 0);
    step();
    idle(); #1;
    chk("R9 no d_rvalid", d_rvalid, 0);
    chk("R6 i served", i_rvalid, 1);
    d_op(0, mk(5, 0), 0); step();
    chk("R9 dropped write", d_rdata, 16'h4444);
    idle(); step();
  endtask

  task automatic t_out_of_range();
    idle(); d_op(0, mk(12, 5), 0); i_op(0, mk(12, 5), 0); #1;
    chk("R8 d_oor", d_oor, 1);
    chk("R8 i_oor", i_oor, 1);
    chk("R8 no stall", i_stall, 0);
    step();
    idle(); #1;
    chk("R8 no rvalid", {i_rvalid, d_rvalid}, 0);
    // bank 12 shares low bank bits with bank 4; the word there must survive
    d_op(1, mk(12, 1), 16'hDEAD); #1;
    chk("R8 write oor", d_oor, 1);
    step();
    idle(); i_op(0, mk(4, 1), 0); step();
    chk("R8 no write", i_rdata, 16'h0A0A);
    idle(); #1;
    chk("R8 idle oor clear", {i_oor, d_oor}, 0);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    step();
    t_reset();
    t_cross_port();
    t_split_banks();
    t_collide_order();
    t_collide_reads();
    t_wait_drop();
    t_out_of_range();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule